// File: doc/BRIEF.md
# Maskable Event Interrupt Controller

This block gathers a handful of internal status events, captures each one as a sticky flag on its rising edge, and raises one interrupt line whenever any captured flag is also enabled. Two kinds of event share the flag register. Ready events mark the end of host-launched procedures: per-channel acquisition on channel A, the same on channel B, automatic calibration, and automatic delay search. Error events are a data parity error and drift of the interface clock delay away from its calibrated value.

The host sees a plain register port. Writes take effect on the clock edge, and reads are combinational from the address. Through this port the host programs the enable mask, reads the flags to find the cause, and clears all flags with a control bit that resets itself. Two general-purpose output pins each pick one of four sources: a host-written level, the interrupt, or one of two internal signals. Each pin has its own programmable inversion and a register stage on its output.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the flags, enable mask, pin selects, inversions and generic output levels are all zero, so `irq_o` and `gpio_o` are low.
- R2: A 0-to-1 transition on `evt_i[k]` sets flag k at that clock edge. A level that is already high when reset is released sets nothing. Event bits are 0 = acquisition A done, 1 = acquisition B done, 2 = calibration done, 3 = delay search done, 4 = parity error, 5 = clock-delay drift.
- R3: A flag stays set after its event falls, and it is set whether or not its enable bit is set.
- R4: `irq_o` is high exactly when some flag is set and its bit in the enable register (address 0) is set. Enabling an already-set flag raises `irq_o` after that write.
- R5: Writing a 1 to bit 0 of the control register (address 2) clears every flag at that edge, and `irq_o` with them. The control register always reads as zero, and a write of 0 there clears nothing.
- R6: An event that rises in the same cycle as a clear keeps its flag set.
- R7: A write to the flag register (address 1) changes no flag.
- R8: The pin-select register (address 3) holds a 2-bit source code per pin, pin 0 in bits 1:0 and pin 1 in bits 3:2. The codes are 0 = generic level (address 4, bit p for pin p), 1 = interrupt, 2 = `sig_a_i`, 3 = `sig_b_i`. The chosen source appears on `gpio_o` one clock after it is sampled.
- R9: Bit 4 of address 3 inverts pin 0 and bit 5 inverts pin 1.
- R10: Reads return the enable mask at 0, the flags at 1, zero at 2, the pin-select register at 3, the generic levels at 4, and zero at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 6 | Event levels, one bit per source |
| sig_a_i | input | 1 | Internal signal A, observable on a pin |
| sig_b_i | input | 1 | Internal signal B, observable on a pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data, combinational from `rd_addr_i` |
| irq_o | output | 1 | Interrupt, high while an enabled flag is set |
| gpio_o | output | 2 | General-purpose pin levels |

## Verification
The assertions run on every cycle. They check that a rising event always leaves its flag set, that flags never drop without a clear, that a clear leaves only the same-cycle risers, and that a fully masked controller never interrupts. They also check that the control address reads zero, that the mask changes only on its own write, and that the generic and interrupt routes reach a pin with the right polarity one cycle later. Other behaviour can only be seen through the bench's sequences: a level held high across reset, a write aimed at the flag register, the later enabling of a flag that is already set, and the exact interaction between an event and a clear in the same cycle.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    // Register addresses (decoded by the register file)
    localparam int ADR_ENABLE = 0;
    localparam int ADR_FLAGS  = 1;
    localparam int ADR_CTRL   = 2;
    localparam int ADR_PINSEL = 3;
    localparam int ADR_GENOUT = 4;

    // Bit of the control register that clears all flags
    localparam int CTRL_CLR_BIT = 0;

    // Pin source codes
    typedef enum logic [1:0] {
        SRC_GENERIC = 2'd0,
        SRC_IRQ     = 2'd1,
        SRC_SIG_A   = 2'd2,
        SRC_SIG_B   = 2'd3
    } pin_src_e;

endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
    parameter int NUM_EVT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               clr_i,
    output logic [NUM_EVT-1:0] flags_o
);

    typedef struct packed {
        logic [NUM_EVT-1:0] prev;
        logic [NUM_EVT-1:0] flags;
    } bank_t;

    bank_t              st_d, st_q;
    logic [NUM_EVT-1:0] rise;

    // Per-event edge detect against the previous sampled level
    for (genvar k = 0; k < NUM_EVT; k++) begin : g_edge
        assign rise[k] = evt_i[k] & ~st_q.prev[k];
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = evt_i;
        if (clr_i) begin
            st_d.flags = rise;               // new edges survive a clear
        end else begin
            st_d.flags = st_q.flags | rise;  // sticky
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev  <= '1;                // a level held across reset is not an edge
            st_q.flags <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

    p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((st_q.flags & $past(rise)) == $past(rise)));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((st_q.flags & $past(st_q.flags)) == $past(st_q.flags)));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((st_q.flags & ~$past(rise)) == '0));

    p_clear_race_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (rise != '0)) |=> (st_q.flags != '0));

endmodule

// File: rtl/evt_reg_file.sv
module evt_reg_file
    import evt_irq_pkg::*;
#(
    parameter int NUM_EVT = 6,
    parameter int NUM_PIN = 2,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [DATA_W-1:0]    rd_data_o,
    input  logic [NUM_EVT-1:0]   flags_i,
    output logic [NUM_EVT-1:0]   enable_o,
    output logic                 clr_o,
    output logic [2*NUM_PIN-1:0] pin_sel_o,
    output logic [NUM_PIN-1:0]   pin_inv_o,
    output logic [NUM_PIN-1:0]   gen_out_o
);

    localparam int SEL_W   = 2 * NUM_PIN;
    localparam int PSEL_W  = SEL_W + NUM_PIN;   // selects then inversions

    typedef struct packed {
        logic [NUM_EVT-1:0] enable;
        logic [SEL_W-1:0]   sel;
        logic [NUM_PIN-1:0] inv;
        logic [NUM_PIN-1:0] gen;
    } regs_t;

    regs_t st_d, st_q;

    logic wr_enable, wr_ctrl, wr_psel, wr_gen;

    always_comb begin
        wr_enable = wr_en_i && (wr_addr_i == ADDR_W'(ADR_ENABLE));
        wr_ctrl   = wr_en_i && (wr_addr_i == ADDR_W'(ADR_CTRL));
        wr_psel   = wr_en_i && (wr_addr_i == ADDR_W'(ADR_PINSEL));
        wr_gen    = wr_en_i && (wr_addr_i == ADDR_W'(ADR_GENOUT));
    end

    always_comb begin
        st_d = st_q;
        if (wr_enable) st_d.enable = wr_data_i[NUM_EVT-1:0];
        if (wr_psel) begin
            st_d.sel = wr_data_i[SEL_W-1:0];
            st_d.inv = wr_data_i[PSEL_W-1:SEL_W];
        end
        if (wr_gen) st_d.gen = wr_data_i[NUM_PIN-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Self-resetting clear: a strobe, never stored
    assign clr_o = wr_ctrl && wr_data_i[CTRL_CLR_BIT];

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            ADDR_W'(ADR_ENABLE): rd_data_o[NUM_EVT-1:0] = st_q.enable;
            ADDR_W'(ADR_FLAGS):  rd_data_o[NUM_EVT-1:0] = flags_i;
            ADDR_W'(ADR_PINSEL): rd_data_o[PSEL_W-1:0]  = {st_q.inv, st_q.sel};
            ADDR_W'(ADR_GENOUT): rd_data_o[NUM_PIN-1:0] = st_q.gen;
            default:             rd_data_o = '0;
        endcase
    end

    assign enable_o  = st_q.enable;
    assign pin_sel_o = st_q.sel;
    assign pin_inv_o = st_q.inv;
    assign gen_out_o = st_q.gen;

    wire unused_wdata = ^wr_data_i;

    p_ctrl_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == ADDR_W'(ADR_CTRL)) |-> (rd_data_o == '0));

    p_enable_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_enable |=> $stable(enable_o));

endmodule

// File: rtl/evt_pin_mux.sv
module evt_pin_mux
    import evt_irq_pkg::*;
#(
    parameter int NUM_PIN = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*NUM_PIN-1:0] sel_i,
    input  logic [NUM_PIN-1:0]   inv_i,
    input  logic [NUM_PIN-1:0]   gen_i,
    input  logic                 irq_i,
    input  logic                 sig_a_i,
    input  logic                 sig_b_i,
    output logic [NUM_PIN-1:0]   pin_o
);

    typedef struct packed {
        logic [NUM_PIN-1:0] pin;
    } mux_t;

    mux_t               st_d, st_q;
    logic [NUM_PIN-1:0] routed;

    function automatic logic pick(input logic [1:0] code, input logic gen,
                                  input logic irq, input logic a, input logic b);
        case (pin_src_e'(code))
            SRC_GENERIC: pick = gen;
            SRC_IRQ:     pick = irq;
            SRC_SIG_A:   pick = a;
            default:     pick = b;
        endcase
    endfunction

    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
        assign routed[p] = pick(sel_i[2*p +: 2], gen_i[p], irq_i, sig_a_i, sig_b_i)
                           ^ inv_i[p];

        p_generic_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_i[2*p +: 2] == 2'd0 && !inv_i[p]) |=> (pin_o[p] == $past(gen_i[p])));

        p_irq_polarity_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_i[2*p +: 2] == 2'd1 && inv_i[p]) |=> (pin_o[p] == !$past(irq_i)));
    end

    always_comb begin
        st_d     = st_q;
        st_d.pin = routed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_o = st_q.pin;

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
    parameter int NUM_EVT = 6,
    parameter int NUM_PIN = 2,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               sig_a_i,
    input  logic               sig_b_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               irq_o,
    output logic [NUM_PIN-1:0] gpio_o
);

    logic [NUM_EVT-1:0]   flags_w;
    logic [NUM_EVT-1:0]   enable_w;
    logic                 clr_w;
    logic [2*NUM_PIN-1:0] sel_w;
    logic [NUM_PIN-1:0]   inv_w;
    logic [NUM_PIN-1:0]   gen_w;

    evt_flag_bank #(.NUM_EVT(NUM_EVT)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .clr_i   (clr_w),
        .flags_o (flags_w)
    );

    evt_reg_file #(
        .NUM_EVT (NUM_EVT),
        .NUM_PIN (NUM_PIN),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .flags_i   (flags_w),
        .enable_o  (enable_w),
        .clr_o     (clr_w),
        .pin_sel_o (sel_w),
        .pin_inv_o (inv_w),
        .gen_out_o (gen_w)
    );

    // Interrupt: any flag that is also enabled
    always_comb begin
        irq_o = |(flags_w & enable_w);
    end

    evt_pin_mux #(.NUM_PIN(NUM_PIN)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel_w),
        .inv_i   (inv_w),
        .gen_i   (gen_w),
        .irq_i   (irq_o),
        .sig_a_i (sig_a_i),
        .sig_b_i (sig_b_i),
        .pin_o   (gpio_o)
    );

    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_w == '0) |-> !irq_o);

endmodule

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] evt = '0;
    logic       sig_a = 1'b0, sig_b = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq;
    logic [1:0] gpio;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .sig_a_i   (sig_a),
        .sig_b_i   (sig_b),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .irq_o     (irq),
        .gpio_o    (gpio)
    );

    // {evt[5:0], wr_en, wr_addr[2:0], wr_data[7:0], exp_irq, exp_flags[5:0]}
    localparam logic [24:0] VEC [NV] = '{
        {6'h00, 1'b0, 3'd0, 8'h00, 1'b0, 6'h00},  // idle
        {6'h01, 1'b1, 3'd0, 8'h01, 1'b1, 6'h01},  // R2 rise + enable bit0
        {6'h01, 1'b0, 3'd0, 8'h00, 1'b1, 6'h01},  // R3 held level, flag stays
        {6'h00, 1'b1, 3'd2, 8'h01, 1'b0, 6'h00},  // R5 clear
        {6'h10, 1'b0, 3'd0, 8'h00, 1'b0, 6'h10},  // R3 parity flag while masked
        {6'h10, 1'b1, 3'd0, 8'h10, 1'b1, 6'h10},  // R4 enable set flag
        {6'h12, 1'b1, 3'd2, 8'h01, 1'b0, 6'h02},  // R6 rise during clear
        {6'h00, 1'b1, 3'd1, 8'h3F, 1'b0, 6'h02},  // R7 flag write ignored
        {6'h2C, 1'b1, 3'd0, 8'h3F, 1'b1, 6'h2E},  // R2 several rises
        {6'h2C, 1'b1, 3'd2, 8'h00, 1'b1, 6'h2E},  // R5 ctrl write of 0
        {6'h00, 1'b1, 3'd2, 8'h01, 1'b0, 6'h00},  // R5 clear all
        {6'h3F, 1'b0, 3'd0, 8'h00, 1'b1, 6'h3F}   // R2 all rise
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        chk(tag, 32'(rd_data), 32'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL R1 watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 gpio", 32'(gpio), 0);
        rd("R1 enable", 3'd0, 8'h00);
        rd("R1 flags", 3'd1, 8'h00);
        rd("R1 pinsel", 3'd3, 8'h00);

        // Vector table: one cycle per entry, check after the edge
        for (int i = 0; i < NV; i++) begin
            evt     = VEC[i][24:19];
            wr_en   = VEC[i][18];
            wr_addr = VEC[i][17:15];
            wr_data = VEC[i][14:7];
            rd_addr = 3'd1;
            @(negedge clk);
            wr_en = 1'b0;
            chk($sformatf("R4 vec%0d irq", i), 32'(irq), 32'(VEC[i][6]));
            chk($sformatf("R2 vec%0d flags", i), 32'(rd_data), 32'(VEC[i][5:0]));
        end

        // R10 readback
        rd("R10 enable", 3'd0, 8'h3F);
        rd("R10 unused addr", 3'd7, 8'h00);
        rd("R5 ctrl reads zero", 3'd2, 8'h00);

        // R8 generic level route
        wr(3'd4, 8'h02);
        rd("R10 genout", 3'd4, 8'h02);
        @(negedge clk);
        chk("R8 generic", 32'(gpio), 32'h2);

        // R8 pin0=irq, pin1=sig_a
        wr(3'd3, 8'h09);
        rd("R10 pinsel", 3'd3, 8'h09);
        @(negedge clk);
        chk("R8 irq/sig_a", 32'(gpio), 32'h1);
        sig_a = 1'b1;
        @(negedge clk);
        chk("R8 sig_a high", 32'(gpio), 32'h3);

        // R8 pin1=sig_b
        wr(3'd3, 8'h0D);
        @(negedge clk);
        chk("R8 sig_b", 32'(gpio), 32'h1);

        // R9 both inverted
        wr(3'd3, 8'h3D);
        @(negedge clk);
        chk("R9 inverted", 32'(gpio), 32'h2);

        // R5 clear drops irq; inverted pin0 then goes high
        wr(3'd2, 8'h01);
        chk("R5 irq after clear", 32'(irq), 0);
        @(negedge clk);
        chk("R9 inverted low irq", 32'(gpio), 32'h3);

        // R2 level held across reset is not an edge; R1 reset state again
        evt = 6'h3F;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd("R2 held level no flag", 3'd1, 8'h00);
        chk("R1 irq after reset", 32'(irq), 0);
        chk("R1 gpio after reset", 32'(gpio), 0);
        rd("R1 enable after reset", 3'd0, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule